// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets synchronous logic read and write a byte-wide asynchronous static RAM that has 19 address bits, 8 data bits, active-low select, write and output-enable strobes and a shared data bus. The user side is a valid/ready request port that carries an address, write data and a read/write flag. Read results come back on a one-cycle response pulse. The controller registers every strobe, so the RAM pins never glitch. The bus driver is split into a data output and an enable, which the chip-level pad ring turns into a tristate pin.

Each access runs through the same phase order: address setup, strobe, hold, recovery, idle. The number of clocks spent in the strobe and recovery phases comes from parameters. The integrator picks these values so that the RAM's pulse-width, access and recovery minimums are met at the chosen clock period. At 50 MHz, the defaults of two strobe clocks and one recovery clock give 40 ns of write pulse or read access and 20 ns of recovery.

Writes keep output enable high for the whole access and let the write strobe set the timing. The data driver turns on in the setup cycle and stays on through the cycle after the write strobe rises, so data is still held when the RAM latches it. Between accesses the RAM is deselected, so it sits in standby with its outputs off.

Back-pressure: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Ready is high only while the controller is idle. The requester must hold its fields steady while valid is high and ready is low. The response has no ready: `rsp_valid` is a single-cycle pulse, and the consumer must take `rsp_rdata` then. `rsp_rdata` keeps its value until the next read completes.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `ram_cs_n`, `ram_we_n` and `ram_oe_n` are 1, `ram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is accepted only on an edge where `req_ready` is 1. `req_ready` is 0 in every cycle of the access that follows. Changes on the request fields during that time have no effect on the access.
- R3: A write (`req_write`=1) runs in this order. First, one cycle with `ram_cs_n`=0 and `ram_we_n`=1. Then exactly WR_PULSE_CYC cycles with `ram_we_n`=0. Then one cycle with `ram_cs_n`=0 and `ram_we_n`=1. Then RECOVERY_CYC cycles with `ram_cs_n`=1. `ram_oe_n` stays 1 throughout. `ram_dq_oe`=1 with `ram_dq_o` equal to the request data in the first three phases, and 0 in recovery. `req_ready` is 0 for exactly 2+WR_PULSE_CYC+RECOVERY_CYC cycles.
- R4: A read (`req_write`=0) runs in this order. First, one cycle with `ram_cs_n`=0 and `ram_oe_n`=1. Then exactly RD_ACCESS_CYC cycles with `ram_oe_n`=0. Then one cycle with `ram_cs_n`=0 and `ram_oe_n`=1. Then RECOVERY_CYC cycles with `ram_cs_n`=1. `ram_we_n`=1 and `ram_dq_oe`=0 throughout. `req_ready` is 0 for exactly 2+RD_ACCESS_CYC+RECOVERY_CYC cycles.
- R5: `ram_dq_i` is sampled at the end of the last output-enable cycle of a read. That value appears on `rsp_rdata`, with `rsp_valid`=1, for exactly the one cycle that follows. `rsp_rdata` then holds that value.
- R6: While `ram_cs_n` is 0, `ram_addr` equals the accepted request address and does not change.
- R7: `ram_dq_oe` is never 1 in a cycle where `ram_oe_n` is 0, or in the cycle right after one. `ram_we_n` is 0 only while `ram_cs_n` is 0 and `ram_oe_n` is 1.
- R8: Whenever the controller is idle (`req_ready`=1), all three strobes are 1 and `ram_dq_oe` is 0.
- R9: If `req_valid` is held high with the next request, that request is accepted in the first cycle `req_ready` returns to 1. `ram_addr` then carries the new address in the following cycle.
- R10: Data written to any address, including 0x00000 and 0x7FFFF, is returned by a later read of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data, held until the next read |
| ram_addr | output | 19 | RAM address pins |
| ram_cs_n | output | 1 | RAM select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_o | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable of the controller's data driver |
| ram_dq_i | input | 8 | Data from the RAM bus |

## Verification
A wrong phase state or a miscounted phase timer shows up within one access at the strobe pins. It appears as a write or output-enable pulse one clock too long or too short, or as a ready that returns too early or too late. Both are visible in the cycle where the phase ends. A driver-enable fault shows in a single cycle as overlap between `ram_dq_oe` and a low output enable. A capture made one cycle off, or a lost address latch, gives wrong data on the read-back of a known pattern, one access later.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RECOVER
  } sramc_state_e;
endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  AST_TMR_LOAD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val))); // R3
endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          capture,
  input  logic [DW-1:0] ram_dq_i,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          write_q,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= ram_dq_i;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(rsp_rdata)); // R5
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW            = 19,
  parameter int DW            = 8,
  parameter int WR_PULSE_CYC  = 2,
  parameter int RD_ACCESS_CYC = 2,
  parameter int RECOVERY_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs_n,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_i
);
  import sramc_pkg::*;

  localparam int MAX_A  = (WR_PULSE_CYC > RD_ACCESS_CYC) ? WR_PULSE_CYC : RD_ACCESS_CYC;
  localparam int MAX_C  = (MAX_A > RECOVERY_CYC) ? MAX_A : RECOVERY_CYC;
  localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(RECOVERY_CYC - 1);

  sramc_state_e state_q, state_d;
  logic          accept, capture, op_wr, tmr_done, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic          write_q;
  logic [DW-1:0] wdata_q;
  logic [AW-1:0] addr_q;
  logic          cs_n_q, we_n_q, oe_n_q, drv_q;
  logic          sel_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign op_wr     = (state_q == ST_IDLE) ? req_write : write_q;
  assign capture   = (state_q == ST_STROBE) && !write_q && tmr_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_SETUP;
      ST_SETUP:   state_d = ST_STROBE;
      ST_STROBE:  if (tmr_done) state_d = ST_HOLD;
      ST_HOLD:    state_d = ST_RECOVER;
      ST_RECOVER: if (tmr_done) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = RC_LOAD;
    if (state_q == ST_SETUP) begin
      tmr_load = 1'b1;
      tmr_val  = write_q ? WR_LOAD : RD_LOAD;
    end else if (state_q == ST_HOLD) begin
      tmr_load = 1'b1;
      tmr_val  = RC_LOAD;
    end
  end

  assign sel_d = (state_d == ST_SETUP) || (state_d == ST_STROBE) || (state_d == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= !sel_d;
      we_n_q  <= !((state_d == ST_STROBE) && op_wr);
      oe_n_q  <= !((state_d == ST_STROBE) && !op_wr);
      drv_q   <= sel_d && op_wr;
    end
  end

  sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sramc_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_write (req_write),
    .capture   (capture),
    .ram_dq_i  (ram_dq_i),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .write_q   (write_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign ram_addr  = addr_q;
  assign ram_dq_o  = wdata_q;
  assign ram_cs_n  = cs_n_q;
  assign ram_we_n  = we_n_q;
  assign ram_oe_n  = oe_n_q;
  assign ram_dq_oe = drv_q;

  AST_DRV_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (ram_oe_n && $past(ram_oe_n))); // R7
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_cs_n && ram_oe_n)); // R7
  AST_DATA_HELD_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> ram_dq_oe); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe)); // R8
  AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!ram_oe_n) && ram_oe_n)); // R5
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> !req_ready); // R2
endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
  localparam int W = 2;
  localparam int A = 2;
  localparam int R = 1;
  localparam logic [7:0] BLANK = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] ram_addr;
  logic        ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [7:0]  ram_dq_o;
  logic [7:0]  ram_dq_i;

  int checks = 0, errors = 0, contention = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sram_async_ctrl #(.AW(19), .DW(8), .WR_PULSE_CYC(W), .RD_ACCESS_CYC(A),
                    .RECOVERY_CYC(R)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i));

  // behavioural RAM
  bit [7:0] mem [bit [18:0]];
  bit [7:0] shadow [bit [18:0]];
  wire wr_act = !ram_cs_n && !ram_we_n;
  always @(negedge wr_act) mem[ram_addr] = ram_dq_o;
  always @(ram_cs_n or ram_we_n or ram_oe_n or ram_addr) begin
    if (!ram_cs_n && ram_we_n && !ram_oe_n)
      ram_dq_i = mem.exists(ram_addr) ? mem[ram_addr] : BLANK;
    else
      ram_dq_i = 8'h00;
  end

  logic prev_oe_n = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_dq_oe && (!ram_oe_n || !prev_oe_n)) contention++;
      if (!ram_we_n && (!ram_oe_n || ram_cs_n)) contention++;
    end
    prev_oe_n <= ram_oe_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~wr; // R2 junk
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid,
        "R1", "outputs in reset", {req_ready, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid,
        "R8", "idle after reset", {req_ready, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid}, 6'b111100);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    int e_seq = 0, e_dat = 0, e_adr = 0, e_rdy = 0;
    issue(1'b1, a, d);
    for (int c = 1; c <= 2 + W + R; c++) begin
      bit xcs, xwe, xdrv;
      xcs  = (c > 2 + W);
      xwe  = !(c >= 2 && c <= 1 + W);
      xdrv = (c <= 2 + W);
      if (ram_cs_n !== xcs || ram_we_n !== xwe || ram_oe_n !== 1'b1 || ram_dq_oe !== xdrv) e_seq++;
      if (xdrv && ram_dq_o !== d) e_dat++;
      if (!ram_cs_n && ram_addr !== a) e_adr++;
      if (req_ready) e_rdy++;
      @(negedge clk);
    end
    shadow[a] = d;
    chk(e_seq == 0, "R3", "write strobe cycles wrong", e_seq, 0);
    chk(e_dat == 0, "R3", "write data cycles wrong", e_dat, 0);
    chk(e_adr == 0, "R6", "address cycles wrong", e_adr, 0);
    chk(e_rdy == 0, "R2", "ready high while busy", e_rdy, 0);
    chk(req_ready === 1'b1, "R3", "ready after write", req_ready, 1);
  endtask

  task automatic t_read(input logic [18:0] a);
    int e_seq = 0, e_adr = 0, e_rsp = 0;
    logic [7:0] exp_d, got;
    exp_d = shadow.exists(a) ? shadow[a] : BLANK;
    got = 8'h00;
    issue(1'b0, a, 8'hC3);
    for (int c = 1; c <= 2 + A + R; c++) begin
      bit xcs, xoe;
      xcs = (c > 2 + A);
      xoe = !(c >= 2 && c <= 1 + A);
      if (ram_cs_n !== xcs || ram_oe_n !== xoe || ram_we_n !== 1'b1 || ram_dq_oe !== 1'b0) e_seq++;
      if (!ram_cs_n && ram_addr !== a) e_adr++;
      if (rsp_valid !== (c == 2 + A)) e_rsp++;
      if (c == 2 + A) got = rsp_rdata;
      @(negedge clk);
    end
    chk(e_seq == 0, "R4", "read strobe cycles wrong", e_seq, 0);
    chk(e_adr == 0, "R6", "address cycles wrong", e_adr, 0);
    chk(e_rsp == 0, "R5", "rsp_valid cycles wrong", e_rsp, 0);
    chk(got == exp_d, "R10", "read data", got, exp_d);
    chk(rsp_rdata == exp_d && req_ready, "R5", "rdata held", rsp_rdata, exp_d);
  endtask

  task automatic t_back_to_back(input logic [18:0] a1, input logic [7:0] d1,
                                input logic [18:0] a2, input logic [7:0] d2);
    int low = 0;
    @(negedge clk);
    req_write = 1'b1; req_addr = a1; req_wdata = d1; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = a2; req_wdata = d2;
    while (!req_ready) begin low++; @(negedge clk); end
    chk(low == 2 + W + R, "R9", "busy cycles before reaccept", low, 2 + W + R);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ram_cs_n && ram_addr == a2, "R9", "second address in setup", ram_addr, a2);
    while (!req_ready) @(negedge clk);
    shadow[a1] = d1;
    shadow[a2] = d2;
  endtask

  initial begin
    t_reset();
    t_write(19'h00000, 8'h11);
    t_write(19'h7FFFF, 8'hEE);
    t_write(19'h12345, 8'hA7);
    t_read(19'h00000);
    t_read(19'h7FFFF);
    t_read(19'h12345);
    t_read(19'h00001);
    t_back_to_back(19'h0ABCD, 8'h3C, 19'h0ABCE, 8'hC3);
    t_read(19'h0ABCD);
    t_read(19'h0ABCE);
    t_write(19'h12345, 8'h00);
    t_read(19'h12345);
    chk(contention == 0, "R7", "driver/strobe overlap cycles", contention, 0);
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      report();
    end
  end
endmodule